// File: doc/BRIEF.md
# Immediate Byte Override Unit

This unit sits between instruction fetch and the datapath and decides which immediate value the current instruction sees. Fetch hands it the three immediate bytes that follow the opcode byte in a four-byte fetch word. The datapath receives the effective immediate from it. Normally the raw bytes pass through untouched. An override instruction can replace one of those bytes with a computed value. That value comes from the first read port of the register file.

An override instruction is marked by a nonzero override code while the instruction-advance strobe is high. Code 1 targets byte 0 (bits 7:0), code 2 targets byte 1 (bits 15:8) and code 3 targets byte 2 (bits 23:16). Consecutive override instructions add to one another. To replace several bytes, issue one override instruction per byte, back to back. The next ordinary instruction then sees the replaced bytes in place of its literal ones, and its remaining bytes stay raw. When that instruction advances, every override is dropped.

Control is a two-state machine. `ST_PASS` means no byte is pending. `ST_PEND` means at least one byte is held. The transition from `ST_PASS` to `ST_PEND` fires on an advance with a nonzero code. `ST_PEND` stays in `ST_PEND` on further override advances. `ST_PEND` returns to `ST_PASS` on an advance with code 0, and at that point all held bytes are released.

Top module: `imm_override_unit`

## Requirements
- R1: While reset is asserted and right after it, no byte is held, the state is `ST_PASS`, and `eff_imm` equals `raw_imm`.
- R2: With no byte held, `eff_imm` equals `raw_imm` for every raw pattern, in the same cycle.
- R3: An advance with override code k (1, 2 or 3) stores `reg_rdata` into byte k-1, where byte 0 is bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16. From the next cycle on, that byte of `eff_imm` carries the stored value whatever `raw_imm` holds.
- R4: A byte that has not been stored since the last release passes its raw value, even while other bytes are replaced.
- R5: Override advances on successive instructions accumulate. Codes 1, 2 and 3 in sequence replace the whole 24-bit field.
- R6: The first advance with code 0 after one or more override advances releases every held byte. It also returns the state to `ST_PASS`. From the following cycle on, `eff_imm` equals `raw_imm`.
- R7: While `instr_adv` is low, `ovr_code` and `reg_rdata` have no effect: nothing is stored and nothing is released.
- R8: A second override advance with the same code replaces the earlier stored value for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_imm | input | 24 | Raw immediate bytes from fetch |
| reg_rdata | input | 8 | Register-file first read port value |
| ovr_code | input | 2 | 0 for an ordinary instruction; k = 1..3 overrides byte k-1 |
| instr_adv | input | 1 | High in the cycle the current instruction completes |
| eff_imm | output | 24 | Effective immediate for the datapath |

## Verification
Pass-through is tried with several unrelated raw patterns, both before and after overrides. These separate a true bypass from a stale stored value. Single-byte overrides on byte 0 and on byte 2 are used with raw values that differ in every byte. They show both that the right lane is replaced and that the untouched lanes stay raw. A full three-byte sequence is checked under two different raw words, which shows that the raw field is ignored completely. A following plain advance then shows that the override lasts exactly one instruction. Holding a nonzero code with the strobe low, and repeating one code, separate strobe qualification and last-write-wins from accidental loading.

// File: rtl/imo_pkg.sv
package imo_pkg;
    typedef enum logic {
        ST_PASS = 1'b0,
        ST_PEND = 1'b1
    } imo_state_e;
endpackage

// File: rtl/imo_seq_fsm.sv
module imo_seq_fsm
    import imo_pkg::*;
#(
    parameter int NUM_BYTES = 3,
    parameter int CODE_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_adv,
    input  logic [CODE_W-1:0]    ovr_code,
    output logic [NUM_BYTES-1:0] load_en,
    output logic                 clr,
    output imo_state_e           state
);
    imo_state_e state_q, state_d;
    logic       is_ovr;

    assign is_ovr = (ovr_code != '0) && (ovr_code <= CODE_W'(NUM_BYTES));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: if (instr_adv && is_ovr)  state_d = ST_PEND;
            ST_PEND: if (instr_adv && !is_ovr) state_d = ST_PASS;
            default: state_d = ST_PASS;
        endcase
    end

    always_comb begin
        clr = 1'b0;
        for (int k = 0; k < NUM_BYTES; k++)
            load_en[k] = instr_adv && (ovr_code == CODE_W'(k + 1));
        unique case (state_q)
            ST_PASS: clr = 1'b0;
            ST_PEND: clr = instr_adv && !is_ovr;
            default: clr = 1'b1;
        endcase
    end

    assign state = state_q;

    // R6
    release_to_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && instr_adv && ovr_code == '0) |=> state_q == ST_PASS);

    // R7
    hold_without_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_adv |=> $stable(state_q));
endmodule

// File: rtl/imo_byte_slot.sv
module imo_byte_slot #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] raw_byte,
    output logic [BYTE_W-1:0] eff_byte,
    output logic              valid
);
    logic [BYTE_W-1:0] held_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            held_q  <= wr_data;
            valid_q <= 1'b1;
        end else if (clr) begin
            valid_q <= 1'b0;
        end
    end

    assign eff_byte = valid_q ? held_q : raw_byte;
    assign valid    = valid_q;

    // R6
    clear_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> !valid_q);

    // R8
    reload_latest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_q && held_q == $past(wr_data)));
endmodule

// File: rtl/imm_override_unit.sv
module imm_override_unit
    import imo_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int CODE_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BYTES*BYTE_W-1:0] raw_imm,
    input  logic [BYTE_W-1:0]           reg_rdata,
    input  logic [CODE_W-1:0]           ovr_code,
    input  logic                        instr_adv,
    output logic [NUM_BYTES*BYTE_W-1:0] eff_imm
);
    logic [NUM_BYTES-1:0] load_en;
    logic [NUM_BYTES-1:0] valid_vec;
    logic                 clr;
    imo_state_e           state;

    imo_seq_fsm #(.NUM_BYTES(NUM_BYTES), .CODE_W(CODE_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_adv (instr_adv),
        .ovr_code  (ovr_code),
        .load_en   (load_en),
        .clr       (clr),
        .state     (state)
    );

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slot
        imo_byte_slot #(.BYTE_W(BYTE_W)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_en[i]),
            .clr      (clr),
            .wr_data  (reg_rdata),
            .raw_byte (raw_imm[i*BYTE_W +: BYTE_W]),
            .eff_byte (eff_imm[i*BYTE_W +: BYTE_W]),
            .valid    (valid_vec[i])
        );

        // R3
        lane_takes_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_adv && ovr_code == CODE_W'(i + 1))
            |=> eff_imm[i*BYTE_W +: BYTE_W] == $past(reg_rdata));
    end

    // R1 R2
    pass_state_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> (valid_vec == '0 && eff_imm == raw_imm));

    // R7
    no_adv_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_adv |=> $stable(valid_vec));

    // R5
    accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_adv && ovr_code != '0) |=> ((valid_vec & $past(valid_vec)) == $past(valid_vec)));
endmodule

// File: tb/imm_override_unit_tb_top.sv
module imm_override_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] raw_imm = '0;
    logic [7:0]  reg_rdata = '0;
    logic [1:0]  ovr_code = '0;
    logic        instr_adv = 1'b0;
    logic [23:0] eff_imm;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    imm_override_unit dut_i (
        .clk(clk), .rst_n(rst_n), .raw_imm(raw_imm), .reg_rdata(reg_rdata),
        .ovr_code(ovr_code), .instr_adv(instr_adv), .eff_imm(eff_imm)
    );

    task automatic chk(input logic [23:0] exp, input string req);
        n_chk++;
        if (eff_imm !== exp) begin
            n_bad++;
            $display("FAIL %s: eff_imm actual %h expected %h", req, eff_imm, exp);
        end
    endtask

    task automatic issue(input logic [1:0] code, input logic [7:0] rd);
        instr_adv = 1'b1; ovr_code = code; reg_rdata = rd;
        @(negedge clk);
        instr_adv = 1'b0; ovr_code = 2'd0; reg_rdata = 8'h00;
    endtask

    task automatic t_reset();
        raw_imm = 24'hA1B2C3;
        @(negedge clk); chk(24'hA1B2C3, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk); chk(24'hA1B2C3, "R1 after reset");
    endtask

    task automatic t_pass();
        raw_imm = 24'h000000; #1 chk(24'h000000, "R2 zero");
        raw_imm = 24'hFFFFFF; #1 chk(24'hFFFFFF, "R2 ones");
        raw_imm = 24'h5A3C96; #1 chk(24'h5A3C96, "R2 mixed");
        @(negedge clk);
    endtask

    task automatic t_single();
        issue(2'd1, 8'h5A);
        raw_imm = 24'h112233; #1 chk(24'h11225A, "R3 R4 byte0");
        instr_adv = 1'b0; ovr_code = 2'd2; reg_rdata = 8'hEE;
        @(negedge clk); chk(24'h11225A, "R7 code without adv");
        ovr_code = 2'd0;
        issue(2'd0, 8'h77);
        chk(24'h112233, "R6 release");
        raw_imm = 24'h445566;
        issue(2'd3, 8'h9C);
        chk(24'h9C5566, "R3 R4 byte2");
        issue(2'd0, 8'h00);
        chk(24'h445566, "R6 release byte2");
    endtask

    task automatic t_full();
        issue(2'd1, 8'h01);
        issue(2'd2, 8'h02);
        issue(2'd3, 8'h03);
        raw_imm = 24'hFFFFFF; #1 chk(24'h030201, "R5 full ones");
        raw_imm = 24'h8D4E1F; #1 chk(24'h030201, "R5 full mixed");
        issue(2'd0, 8'h00);
        chk(24'h8D4E1F, "R6 expiry");
        raw_imm = 24'h246813; #1 chk(24'h246813, "R6 next instr raw");
        @(negedge clk);
    endtask

    task automatic t_reload();
        raw_imm = 24'hABCDEF;
        issue(2'd2, 8'h10);
        chk(24'hAB10EF, "R8 first load");
        issue(2'd2, 8'h20);
        chk(24'hAB20EF, "R8 reload wins");
        issue(2'd0, 8'h00);
        chk(24'hABCDEF, "R6 after reload");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_pass();
                t_single();
                t_full();
                t_reload();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule